// File: doc/BRIEF.md
# Two-Stage Separable Switch Allocator

This block decides, every clock cycle, which flits in a virtual-channel router may cross the crossbar. It works in two stages. In the first stage, each input port looks at its virtual channels, starting from a per-port round-robin pointer, and selects the first one that is ready and eligible. That channel then raises a request for its output port. In the second stage, each output port looks at the requesting input ports, starting from its own round-robin pointer, and grants exactly one of them.

A head flit, or a single-flit packet, that has no downstream channel yet is given the lowest-numbered free output VC of its own virtual network in the same cycle it wins. There is no separate VC-allocation pass. Every grant appears on registered per-input outputs one cycle after the inputs are sampled. A grant on an input port also stands for one credit returned upstream for that channel. A registered one-hot-per-output vector tells the output side which downstream VC loses one credit.

The surrounding router supplies the per-VC state: readiness, destination port, any bound output VC, and the tail flag. It also supplies the per-output-VC free and credit flags. The block keeps only its two sets of rotation pointers.

Top module: `sw_alloc_2stage`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with nothing ready, every grant output and `credit_take` are zero. Both sets of pointers restart at index 0.
- R2: An input VC (flat index v = port*N_VC + vc) is eligible only when it is ready and one of the following holds. If it has a bound output VC, that VC has a credit at its destination port. If it has no bound VC, at least one output VC of its own virtual network (vc / VC_PER_NET) is free at that port.
- R3: The first stage of each input port picks the first eligible VC found by searching upward from the port's VC pointer and wrapping modulo N_VC.
- R4: The second stage of each output port grants the first requesting input found by searching upward from the port's input pointer and wrapping modulo N_IN. The granted input's `gnt_port` is that output.
- R5: After a grant, the output port's input pointer becomes the winning input plus one, wrapping to 0.
- R6: After a grant, the winning input port's VC pointer becomes the winning VC plus one, wrapping to 0. An input whose first-stage choice loses the second stage keeps its pointer.
- R7: A winner with no bound VC gets the lowest-indexed free output VC of its virtual network at its port, with `gnt_assign` high. A bound winner keeps its VC, with `gnt_assign` low.
- R8: Each grant sets exactly one bit of `credit_take`, at index port*N_VC + output VC. The number of set bits equals the number of valid grants.
- R9: `gnt_release` is high on a grant exactly when the granted flit's `vc_last` bit is set.
- R10: Grants are registered and appear one clock after the inputs are sampled. In any cycle no input has more than one grant, and no two grants name the same output port.
- R11: Requests do not persist. An input that lost in one cycle and is no longer ready in the next receives no grant.
- R12: A VC that is eligible in every cycle is granted within N_IN*N_VC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vc_ready | input | N_IN*N_VC | Input VC holds a flit waiting for allocation |
| vc_dest | input | N_IN*N_VC*log2(N_OUT) | Output port requested by each input VC |
| vc_bound | input | N_IN*N_VC | Input VC already owns an output VC |
| vc_bound_ovc | input | N_IN*N_VC*log2(N_VC) | Owned output VC, valid when bound |
| vc_last | input | N_IN*N_VC | Waiting flit is a tail or single-flit packet |
| ovc_free | input | N_OUT*N_VC | Output VC is unowned |
| ovc_credit | input | N_OUT*N_VC | Output VC has at least one buffer credit |
| gnt_valid | output | N_IN | Grant for the input port (also one credit returned upstream) |
| gnt_vc | output | N_IN*log2(N_VC) | Granted input VC |
| gnt_port | output | N_IN*log2(N_OUT) | Output port granted |
| gnt_ovc | output | N_IN*log2(N_VC) | Output VC used by the granted flit |
| gnt_assign | output | N_IN | Output VC was newly assigned by this grant |
| gnt_release | output | N_IN | Input VC becomes idle; credit carries the free indication |
| credit_take | output | N_OUT*N_VC | Output VCs losing one credit this cycle |

## Verification
The bench builds the block with four input ports, four output ports and four VCs per port, split into two virtual networks of two VCs each. Four inputs can all aim at one output, so the input-pointer rotation is exercised. A winner's VC pointer can also be seen skipping past lost first-stage choices. With two networks per port, a head flit can be refused because only the other network's VCs are free. It can also receive a non-zero VC as the lowest free one of its own network. The saturated case, with all sixteen VCs aimed at one port, yields the worst-case wait of sixteen cycles for the fairness check.

// File: rtl/sa_pkg.sv
package sa_pkg;

   // Next index in a rotation of n entries
   function automatic int rr_next(input int idx, input int n);
      return (idx + 1 >= n) ? 0 : idx + 1;
   endfunction

endpackage

// File: rtl/sa_rr_pick.sv
// Rotating-priority pick: first set request at or after start, wrapping.
module sa_rr_pick #(
   parameter int N = 4,
   parameter int W = 2
) (
   input  logic [N-1:0] req,
   input  logic [W-1:0] start,
   output logic         found,
   output logic [W-1:0] pick
);
   always_comb begin
      int idx;
      found = 1'b0;
      pick  = '0;
      for (int k = 0; k < N; k++) begin
         idx = int'(start) + k;
         if (idx >= N) idx = idx - N;
         if (!found && req[idx]) begin
            found = 1'b1;
            pick  = W'(idx);
         end
      end
   end
endmodule

// File: rtl/sa_ovc_pick.sv
// Lowest free output VC within the virtual network of a given input VC.
module sa_ovc_pick #(
   parameter int N_VC       = 4,
   parameter int VC_PER_NET = 2,
   parameter int VCW        = 2
) (
   input  logic [N_VC-1:0] free_row,
   input  logic [VCW-1:0]  for_vc,
   output logic            found,
   output logic [VCW-1:0]  ovc
);
   always_comb begin
      found = 1'b0;
      ovc   = '0;
      for (int k = 0; k < N_VC; k++) begin
         if (!found && free_row[k] &&
             ((k / VC_PER_NET) == (int'(for_vc) / VC_PER_NET))) begin
            found = 1'b1;
            ovc   = VCW'(k);
         end
      end
   end
endmodule

// File: rtl/sa_vc_select.sv
// First stage for one input port: eligibility per VC, then rotating pick.
module sa_vc_select #(
   parameter int N_VC       = 4,
   parameter int N_OUT      = 4,
   parameter int VC_PER_NET = 2,
   parameter int OPW        = 2,
   parameter int VCW        = 2
) (
   input  logic [N_VC-1:0]       ready,
   input  logic [N_VC*OPW-1:0]   dest,
   input  logic [N_VC-1:0]       bound,
   input  logic [N_VC*VCW-1:0]   bound_ovc,
   input  logic [N_OUT*N_VC-1:0] ovc_free,
   input  logic [N_OUT*N_VC-1:0] ovc_credit,
   input  logic [VCW-1:0]        ptr,
   output logic                  req,
   output logic [VCW-1:0]        sel_vc,
   output logic [OPW-1:0]        sel_dest
);
   logic [N_VC-1:0] elig;

   always_comb begin
      int   d;
      int   b;
      logic dok;
      logic any_free;
      for (int c = 0; c < N_VC; c++) begin
         d   = int'(dest[c*OPW +: OPW]);
         b   = int'(bound_ovc[c*VCW +: VCW]);
         dok = (d < N_OUT);
         if (!dok) d = 0;
         any_free = 1'b0;
         for (int k = 0; k < N_VC; k++) begin
            if ((k / VC_PER_NET) == (c / VC_PER_NET))
               any_free = any_free | ovc_free[d*N_VC + k];
         end
         elig[c] = ready[c] && dok &&
                   (bound[c] ? ovc_credit[d*N_VC + b] : any_free);
      end
   end

   sa_rr_pick #(.N(N_VC), .W(VCW)) u_vc_arb (
      .req   (elig),
      .start (ptr),
      .found (req),
      .pick  (sel_vc)
   );

   assign sel_dest = dest[int'(sel_vc)*OPW +: OPW];
endmodule

// File: rtl/sw_alloc_2stage.sv
module sw_alloc_2stage #(
   parameter int N_IN       = 4,
   parameter int N_OUT      = 4,
   parameter int N_VC       = 4,
   parameter int VC_PER_NET = 2
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [N_IN*N_VC-1:0]                   vc_ready,
   input  logic [N_IN*N_VC*$clog2(N_OUT)-1:0]     vc_dest,
   input  logic [N_IN*N_VC-1:0]                   vc_bound,
   input  logic [N_IN*N_VC*$clog2(N_VC)-1:0]      vc_bound_ovc,
   input  logic [N_IN*N_VC-1:0]                   vc_last,
   input  logic [N_OUT*N_VC-1:0]                  ovc_free,
   input  logic [N_OUT*N_VC-1:0]                  ovc_credit,
   output logic [N_IN-1:0]                        gnt_valid,
   output logic [N_IN*$clog2(N_VC)-1:0]           gnt_vc,
   output logic [N_IN*$clog2(N_OUT)-1:0]          gnt_port,
   output logic [N_IN*$clog2(N_VC)-1:0]           gnt_ovc,
   output logic [N_IN-1:0]                        gnt_assign,
   output logic [N_IN-1:0]                        gnt_release,
   output logic [N_OUT*N_VC-1:0]                  credit_take
);
   import sa_pkg::*;

   localparam int OPW = $clog2(N_OUT);
   localparam int VCW = $clog2(N_VC);
   localparam int IPW = $clog2(N_IN);

   // Elaboration-time parameter checks
   if (N_IN < 2 || N_OUT < 2 || N_VC < 2) begin : g_bad_size
      $error("sw_alloc_2stage: port and VC counts must be at least 2");
   end
   if (VC_PER_NET < 1 || (N_VC % VC_PER_NET) != 0) begin : g_bad_net
      $error("sw_alloc_2stage: N_VC must be a multiple of VC_PER_NET");
   end

   logic [VCW-1:0]  vc_ptr_q  [N_IN];
   logic [IPW-1:0]  in_ptr_q  [N_OUT];
   logic [N_IN-1:0] in_req;
   logic [VCW-1:0]  in_vc     [N_IN];
   logic [OPW-1:0]  in_dest   [N_IN];
   logic [N_IN-1:0] port_req  [N_OUT];
   logic [N_OUT-1:0] out_found;
   logic [IPW-1:0]  out_win   [N_OUT];
   logic [N_IN-1:0] won;
   logic [N_IN-1:0] won_bound;
   logic [N_IN-1:0] won_last;
   logic [N_IN-1:0] pick_ok;
   logic [VCW-1:0]  pick_ovc  [N_IN];
   logic [VCW-1:0]  won_ovc   [N_IN];
   logic [N_OUT*N_VC-1:0] take_nxt;

   // ---------------- first stage and per-input grant decode ----------------
   for (genvar i = 0; i < N_IN; i++) begin : g_in
      logic [VCW-1:0] bovc;

      sa_vc_select #(
         .N_VC(N_VC), .N_OUT(N_OUT), .VC_PER_NET(VC_PER_NET),
         .OPW(OPW), .VCW(VCW)
      ) u_sel (
         .ready      (vc_ready[i*N_VC +: N_VC]),
         .dest       (vc_dest[i*N_VC*OPW +: N_VC*OPW]),
         .bound      (vc_bound[i*N_VC +: N_VC]),
         .bound_ovc  (vc_bound_ovc[i*N_VC*VCW +: N_VC*VCW]),
         .ovc_free   (ovc_free),
         .ovc_credit (ovc_credit),
         .ptr        (vc_ptr_q[i]),
         .req        (in_req[i]),
         .sel_vc     (in_vc[i]),
         .sel_dest   (in_dest[i])
      );

      assign won_bound[i] = vc_bound[i*N_VC + int'(in_vc[i])];
      assign won_last[i]  = vc_last[i*N_VC + int'(in_vc[i])];
      assign bovc         = vc_bound_ovc[(i*N_VC + int'(in_vc[i]))*VCW +: VCW];

      sa_ovc_pick #(.N_VC(N_VC), .VC_PER_NET(VC_PER_NET), .VCW(VCW)) u_pick (
         .free_row (ovc_free[int'(in_dest[i])*N_VC +: N_VC]),
         .for_vc   (in_vc[i]),
         .found    (pick_ok[i]),
         .ovc      (pick_ovc[i])
      );

      assign won[i] = in_req[i] && out_found[in_dest[i]] &&
                      (out_win[in_dest[i]] == IPW'(i));
      assign won_ovc[i] = won_bound[i] ? bovc : pick_ovc[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            vc_ptr_q[i] <= '0;
         else if (won[i])
            vc_ptr_q[i] <= VCW'(rr_next(int'(in_vc[i]), N_VC));
      end

      // R6: the VC pointer only moves in a cycle that also produced a grant
      a_r6_vcptr_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(vc_ptr_q[i]) |-> gnt_valid[i]);

      // R2: an unbound winner always finds a free VC of its own network
      a_r2_unbound_has_free: assert property (@(posedge clk) disable iff (!rst_n)
         (won[i] && !won_bound[i]) |-> pick_ok[i]);
   end

   // ---------------- second stage ----------------
   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      always_comb begin
         for (int i = 0; i < N_IN; i++)
            port_req[o][i] = in_req[i] && (in_dest[i] == OPW'(o));
      end

      sa_rr_pick #(.N(N_IN), .W(IPW)) u_port_arb (
         .req   (port_req[o]),
         .start (in_ptr_q[o]),
         .found (out_found[o]),
         .pick  (out_win[o])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            in_ptr_q[o] <= '0;
         else if (out_found[o])
            in_ptr_q[o] <= IPW'(rr_next(int'(out_win[o]), N_IN));
      end

      // R5: the input pointer only moves together with a credit take on that port
      a_r5_inptr_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(in_ptr_q[o]) |-> (|credit_take[o*N_VC +: N_VC]));
   end

   // ---------------- credit take and output registers ----------------
   always_comb begin
      take_nxt = '0;
      for (int i = 0; i < N_IN; i++)
         if (won[i])
            take_nxt[int'(in_dest[i])*N_VC + int'(won_ovc[i])] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_valid   <= '0;
         gnt_vc      <= '0;
         gnt_port    <= '0;
         gnt_ovc     <= '0;
         gnt_assign  <= '0;
         gnt_release <= '0;
         credit_take <= '0;
      end else begin
         gnt_valid   <= won;
         gnt_assign  <= won & ~won_bound;
         gnt_release <= won & won_last;
         credit_take <= take_nxt;
         for (int i = 0; i < N_IN; i++) begin
            gnt_vc[i*VCW +: VCW]   <= won[i] ? in_vc[i]   : '0;
            gnt_port[i*OPW +: OPW] <= won[i] ? in_dest[i] : '0;
            gnt_ovc[i*VCW +: VCW]  <= won[i] ? won_ovc[i] : '0;
         end
      end
   end

   // R8: one credit taken per grant
   a_r8_take_per_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(credit_take) == $countones(gnt_valid));

   // R10: no output port granted twice
   always_ff @(posedge clk) begin
      if (rst_n) begin
         for (int a = 0; a < N_IN; a++)
            for (int b = a + 1; b < N_IN; b++)
               if (gnt_valid[a] && gnt_valid[b])
                  a_r10_port_unique: assert (gnt_port[a*OPW +: OPW] != gnt_port[b*OPW +: OPW]);
      end
   end
endmodule

// File: tb/sw_alloc_2stage_test.sv
`timescale 1ns/1ps
module sw_alloc_2stage_test;
   localparam int NI = 4, NO = 4, NV = 4, VPN = 2, OW = 2, VW = 2, NT = NI*NV;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NT-1:0]    t_ready, t_bound, t_last;
   logic [NT*OW-1:0] t_dest;
   logic [NT*VW-1:0] t_bovc;
   logic [NO*NV-1:0] t_free, t_credit;
   logic [NI-1:0]    g_valid, g_assign, g_release;
   logic [NI*VW-1:0] g_vc, g_ovc;
   logic [NI*OW-1:0] g_port;
   logic [NO*NV-1:0] g_take;

   always #10 clk = ~clk;

   sw_alloc_2stage #(.N_IN(NI), .N_OUT(NO), .N_VC(NV), .VC_PER_NET(VPN)) uut (
      .clk(clk), .rst_n(rst_n),
      .vc_ready(t_ready), .vc_dest(t_dest), .vc_bound(t_bound),
      .vc_bound_ovc(t_bovc), .vc_last(t_last),
      .ovc_free(t_free), .ovc_credit(t_credit),
      .gnt_valid(g_valid), .gnt_vc(g_vc), .gnt_port(g_port), .gnt_ovc(g_ovc),
      .gnt_assign(g_assign), .gnt_release(g_release), .credit_take(g_take)
   );

   localparam logic [15:0] T_READY [8] = '{16'hFFFF, 16'hFFFF, 16'h8421, 16'hFFFF,
                                           16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF};
   localparam logic [15:0] T_BOUND [8] = '{16'h0000, 16'hFFFF, 16'h0000, 16'h00FF,
                                           16'hFFFF, 16'hFFFF, 16'h0F0F, 16'h0000};
   localparam logic [15:0] T_LAST  [8] = '{16'h5555, 16'h0000, 16'hFFFF, 16'h0F0F,
                                           16'h1234, 16'h00FF, 16'h3C3C, 16'hAAAA};
   localparam logic [31:0] T_DEST  [8] = '{32'h1B1B1B1B, 32'h00000000, 32'hFFFFFFFF, 32'h9C639C63,
                                           32'h12345678, 32'h00000000, 32'h4E4E4E4E, 32'hE4E4E4E4};
   localparam logic [31:0] T_BOVC  [8] = '{32'h00000000, 32'hE4E4E4E4, 32'h00000000, 32'h11111111,
                                           32'h87654321, 32'hE4E4E4E4, 32'h1B1B1B1B, 32'h00000000};
   localparam logic [15:0] T_FREE  [8] = '{16'hFFFF, 16'h0000, 16'hC000, 16'h0F0F,
                                           16'hFFFF, 16'h0000, 16'h5A5A, 16'hFFFF};
   localparam logic [15:0] T_CRED  [8] = '{16'hFFFF, 16'hA5A5, 16'hFFFF, 16'hFFFF,
                                           16'hFFFF, 16'hA5A5, 16'h3C3C, 16'hFFFF};

   int n_chk = 0;
   int n_bad = 0;
   int m_vptr [NI];
   int m_optr [NO];
   logic [NI-1:0] e_valid, e_assign, e_release;
   int e_vc [NI];
   int e_port [NI];
   int e_ovc [NI];
   logic [NO*NV-1:0] e_take;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_stim();
      t_ready = '0; t_bound = '0; t_last = '0; t_dest = '0;
      t_bovc = '0; t_free = '0; t_credit = '0;
   endtask

   task automatic set_vc(input int v, input int dst, input bit bnd, input int ov, input bit lst);
      t_ready[v] = 1'b1;
      t_dest[v*OW +: OW] = OW'(dst);
      t_bound[v] = bnd;
      t_bovc[v*VW +: VW] = VW'(ov);
      t_last[v] = lst;
   endtask

   task automatic do_reset();
      clear_stim();
      rst_n = 1'b0;
      step();
      step();
      rst_n = 1'b1;
      for (int i = 0; i < NI; i++) m_vptr[i] = 0;
      for (int o = 0; o < NO; o++) m_optr[o] = 0;
   endtask

   function automatic bit m_elig(input int v);
      int c;
      int d;
      c = v % NV;
      d = int'(t_dest[v*OW +: OW]);
      if (!t_ready[v]) return 1'b0;
      if (t_bound[v]) return t_credit[d*NV + int'(t_bovc[v*VW +: VW])];
      for (int k = 0; k < NV; k++)
         if ((k / VPN) == (c / VPN) && t_free[d*NV + k]) return 1'b1;
      return 1'b0;
   endfunction

   // Reference model of one allocation cycle, built from the requirements
   task automatic model_step();
      bit rq [NI];
      int sel [NI];
      int dst [NI];
      e_valid = '0; e_assign = '0; e_release = '0; e_take = '0;
      for (int i = 0; i < NI; i++) begin
         rq[i] = 1'b0; sel[i] = 0; dst[i] = 0;
         e_vc[i] = 0; e_port[i] = 0; e_ovc[i] = 0;
         for (int k = 0; k < NV; k++) begin
            int c;
            c = (m_vptr[i] + k) % NV;
            if (!rq[i] && m_elig(i*NV + c)) begin
               rq[i] = 1'b1; sel[i] = c; dst[i] = int'(t_dest[(i*NV + c)*OW +: OW]);
            end
         end
      end
      for (int o = 0; o < NO; o++) begin
         bit done;
         done = 1'b0;
         for (int k = 0; k < NI; k++) begin
            int i;
            i = (m_optr[o] + k) % NI;
            if (!done && rq[i] && dst[i] == o) begin
               int v;
               done = 1'b1;
               v = i*NV + sel[i];
               e_valid[i] = 1'b1;
               e_vc[i] = sel[i];
               e_port[i] = o;
               e_release[i] = t_last[v];
               if (t_bound[v]) begin
                  e_ovc[i] = int'(t_bovc[v*VW +: VW]);
               end else begin
                  e_assign[i] = 1'b1;
                  e_ovc[i] = -1;
                  for (int q = 0; q < NV; q++)
                     if (e_ovc[i] < 0 && (q / VPN) == (sel[i] / VPN) && t_free[o*NV + q])
                        e_ovc[i] = q;
               end
               e_take[o*NV + e_ovc[i]] = 1'b1;
               m_optr[o] = (i + 1) % NI;
               m_vptr[i] = (sel[i] + 1) % NV;
            end
         end
      end
   endtask

   task automatic compare_all(input int tag);
      for (int i = 0; i < NI; i++) begin
         check($sformatf("R4 valid in%0d step%0d", i, tag), 64'(g_valid[i]), 64'(e_valid[i]));
         if (e_valid[i] && g_valid[i]) begin
            check($sformatf("R3 vc in%0d step%0d", i, tag), 64'(g_vc[i*VW +: VW]), 64'(e_vc[i]));
            check($sformatf("R4 port in%0d step%0d", i, tag), 64'(g_port[i*OW +: OW]), 64'(e_port[i]));
            check($sformatf("R7 ovc in%0d step%0d", i, tag), 64'(g_ovc[i*VW +: VW]), 64'(e_ovc[i]));
            check($sformatf("R7 assign in%0d step%0d", i, tag), 64'(g_assign[i]), 64'(e_assign[i]));
            check($sformatf("R9 release in%0d step%0d", i, tag), 64'(g_release[i]), 64'(e_release[i]));
         end
      end
      check($sformatf("R8 credit_take step%0d", tag), 64'(g_take), 64'(e_take));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: busy inputs during reset produce nothing
      clear_stim();
      t_ready = '1; t_free = '1; t_credit = '1;
      step();
      step();
      check("R1 valid in reset", 64'(g_valid), 64'h0);
      check("R1 take in reset", 64'(g_take), 64'h0);
      do_reset();
      step();
      check("R1 valid after reset", 64'(g_valid), 64'h0);
      check("R1 fields after reset", {g_vc, g_port, g_ovc, g_assign, g_release}, 64'h0);

      // Table walk against the reference model (R3, R4, R7, R8, R9)
      for (int p = 0; p < 2; p++) begin
         for (int e = 0; e < 8; e++) begin
            t_ready = T_READY[e]; t_bound = T_BOUND[e]; t_last = T_LAST[e];
            t_dest = T_DEST[e]; t_bovc = T_BOVC[e]; t_free = T_FREE[e]; t_credit = T_CRED[e];
            model_step();
            step();
            compare_all(p*8 + e);
         end
      end

      // R2 / R7 / R9: eligibility and output VC choice
      do_reset();
      set_vc(1, 2, 0, 0, 0);
      set_vc(6, 3, 0, 0, 0);
      set_vc(8, 1, 1, 3, 0);
      set_vc(15, 1, 1, 2, 1);
      t_free = 16'h3A00;
      t_credit = 16'hFF7F;
      step();
      check("R2 valid pattern", 64'(g_valid), 64'b1001);
      check("R7 in0 ovc lowest free of net", 64'(g_ovc[1:0]), 64'd1);
      check("R7 in0 assign", 64'(g_assign[0]), 64'd1);
      check("R4 in0 port", 64'(g_port[1:0]), 64'd2);
      check("R7 in3 keeps bound ovc", 64'(g_ovc[7:6]), 64'd2);
      check("R7 in3 no assign", 64'(g_assign[3]), 64'd0);
      check("R9 release pattern", 64'(g_release), 64'b1000);
      check("R8 take bits", 64'(g_take), 64'h0240);

      // R6 / R5: pointer movement
      do_reset();
      set_vc(0, 0, 1, 0, 0);
      set_vc(1, 1, 1, 0, 0);
      set_vc(4, 0, 1, 1, 0);
      set_vc(5, 0, 1, 1, 0);
      t_credit = '1;
      step();
      check("R4 cycle1 valid", 64'(g_valid), 64'b0001);
      check("R3 cycle1 in0 vc", 64'(g_vc[1:0]), 64'd0);
      step();
      check("R6 cycle2 valid", 64'(g_valid), 64'b0011);
      check("R6 cycle2 in0 vc", 64'(g_vc[1:0]), 64'd1);
      check("R6 cycle2 in1 vc kept pointer", 64'(g_vc[3:2]), 64'd0);
      step();
      check("R5 cycle3 valid", 64'(g_valid), 64'b0001);
      check("R5 cycle3 in0 vc", 64'(g_vc[1:0]), 64'd0);

      // R11: lost request is not remembered
      do_reset();
      set_vc(0, 0, 1, 0, 0);
      set_vc(4, 0, 1, 1, 0);
      t_credit = '1;
      step();
      check("R11 first winner", 64'(g_valid), 64'b0001);
      t_ready = '0;
      step();
      check("R11 no stale grant", 64'(g_valid), 64'h0);
      check("R11 no stale take", 64'(g_take), 64'h0);

      // R12 / R10: saturated single output
      do_reset();
      for (int v = 0; v < NT; v++) set_vc(v, 0, 1, 0, 0);
      t_credit = '1;
      begin
         int seen_at;
         seen_at = 0;
         for (int cyc = 1; cyc <= NT + 2; cyc++) begin
            step();
            check($sformatf("R10 one grant cycle%0d", cyc), 64'($countones(g_valid)), 64'd1);
            if (seen_at == 0 && g_valid[3] && g_vc[7:6] == 2'd2) seen_at = cyc;
         end
         check("R12 wait for in3 vc2", 64'(seen_at), 64'd12);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule